// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable single-port SRAM with registered inputs and a registered read path. Every control, address and write-data input is sampled on the rising clock edge; read data leaves through an output register, so a word addressed at one edge is on the data bus after the next edge. A word is split into byte lanes that can be written singly, in groups, or all at once.

Accesses start from one of two address strobes: a host strobe that always starts a read, and a controller strobe that starts a read or a write depending on the write inputs. After a start, a step input walks the low two address bits through a four-beat burst, in linear order or in interleaved order chosen by a parameter. A doze input parks the block with its contents kept, and the bus stays off after writes until a new read-bearing cycle.

Top module: `sync_burst_sram`

## Requirements
- R1: The block is selected only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0; a strobe cycle with any other combination writes nothing, and `dout_en` is 0 after the following edge.
- R2: A host-strobe cycle at edge k reads the word at `addr`; after edge k+1, `dout` holds it and `dout_en` is 1 (with `out_en_n` low).
- R3: When `write_all_n` is 0 in a controller-strobe cycle, all four lanes of `din` are stored at `addr`, whatever `lane_wr_en_n` and `lane_sel_n` are.
- R4: When `write_all_n` is 1 and `lane_wr_en_n` is 0, lane i (bits 8i+7..8i) is stored exactly when `lane_sel_n[i]` is 0; with `lane_sel_n` = 4'b1111 the cycle is a read.
- R5: When `write_all_n` and `lane_wr_en_n` are both 1, a controller-strobe cycle is a read.
- R6: After a write cycle `dout_en` stays 0 through following suspend cycles until a strobe or step read cycle drives the bus again.
- R7: With no strobe and `step_n`=0 during a burst, the low two address bits become start+n mod 4 (linear, `INTERLEAVED`=0) or start XOR n (`INTERLEAVED`=1) for beat n, wrapping after four beats; reads and writes both follow this order.
- R8: `out_en_n`=1 forces `dout_en` to 0 at once without disturbing the pipeline; when it returns low the data of the last read appears.
- R9: While `doze` is 1 all strobes and steps are ignored, memory is kept, and `dout_en` is 0 during doze and after it until a new read.
- R10: With both strobes low in one cycle the host strobe wins: `addr` is loaded and the cycle reads, ignoring the write inputs.
- R11: A controller-strobe write stores `din` in the same edge, so a read started at the next edge returns the new word.
- R12: After reset `dout_en` is 0 and no burst is open, so a step cycle does not drive the bus.
- R13: A cycle with no strobe, no step and no write holds `dout` and `dout_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| host_start_n | input | 1 | Host address strobe, read start |
| ctrl_start_n | input | 1 | Controller address strobe |
| step_n | input | 1 | Burst advance |
| write_all_n | input | 1 | Write every lane |
| lane_wr_en_n | input | 1 | Enables the per-lane selects |
| lane_sel_n | input | LANES | Per-lane write selects |
| out_en_n | input | 1 | Output enable, asynchronous |
| doze | input | 1 | Sleep request, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data register |
| dout_en | output | 1 | Bus drive enable for `dout` |

## Verification
The properties assume that the block is deselected before `doze` rises and that doze is not released in the cycle right after a read strobe they watch; the bench always issues a deselect strobe before dozing and never toggles doze around a pending read. They also take the write inputs as settled at the sampling edge, which the bench ensures by changing every input at the falling edge. Two instances share all stimulus, one per burst order, so each address sweep checks both orders against models kept in the bench.

// File: rtl/sbs_pkg.sv
// Shared types and helpers for the burst SRAM.
// Assumes bursts of four beats (two low address bits).
package sbs_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [2:0] {
        CYC_QUIET,   // asleep or no open burst
        CYC_DESEL,   // strobe with the block not selected
        CYC_HOST,    // host strobe: load and read
        CYC_CTRL,    // controller strobe: load, read or write
        CYC_STEP,    // burst advance
        CYC_SUSP     // open burst, nothing new
    } cycle_e;

    // Low address bits for beat n of a burst starting at 'start'.
    function automatic logic [BURST_W-1:0] beat_bits(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] n,
        input logic               interleaved
    );
        return interleaved ? (start ^ n) : (start + n);
    endfunction

endpackage

// File: rtl/sbs_ctrl.sv
// Cycle decoder and burst address keeper.
// Decides per edge what kind of cycle runs, produces the write request
// for this edge and registers the read request for the output stage.
// Assumes ADDR_W > BURST_W.
module sbs_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int LANES       = 4,
    parameter bit INTERLEAVED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              host_start_n,
    input  logic              ctrl_start_n,
    input  logic              step_n,
    input  logic              write_all_n,
    input  logic              lane_wr_en_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              doze,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANES-1:0]  wr_mask,
    output logic              rd_en_q,
    output logic [ADDR_W-1:0] rd_addr_q,
    output logic              hold_q
);
    localparam int HI = ADDR_W - 1;

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic               open_q;
    logic               selected;
    logic               is_wr;
    logic [ADDR_W-1:0]  cur_addr;
    logic [ADDR_W-1:0]  nxt_addr;
    logic [BURST_W-1:0] cnt_nxt;
    cycle_e             kind;

    // Chip-enable decode and lane mask for this edge.
    always_comb begin
        selected = ~en_a_n & en_b & ~en_c_n;
        if (!write_all_n)       wr_mask = '1;
        else if (!lane_wr_en_n) wr_mask = ~lane_sel_n;
        else                    wr_mask = '0;
        is_wr = |wr_mask;
    end

    // Current and next burst addresses.
    always_comb begin
        cnt_nxt  = cnt_q + 1'b1;
        cur_addr = {base_q[HI:BURST_W], beat_bits(base_q[BURST_W-1:0], cnt_q, INTERLEAVED)};
        nxt_addr = {base_q[HI:BURST_W], beat_bits(base_q[BURST_W-1:0], cnt_nxt, INTERLEAVED)};
    end

    // Cycle classification; host strobe outranks controller strobe.
    always_comb begin
        if (doze)                    kind = CYC_QUIET;
        else if (!host_start_n)      kind = selected ? CYC_HOST : CYC_DESEL;
        else if (!ctrl_start_n)      kind = selected ? CYC_CTRL : CYC_DESEL;
        else if (!step_n && open_q)  kind = CYC_STEP;
        else if (open_q)             kind = CYC_SUSP;
        else                         kind = CYC_QUIET;
    end

    // Write request applied at this edge.
    always_comb begin
        wr_en   = is_wr && (kind == CYC_CTRL || kind == CYC_STEP || kind == CYC_SUSP);
        case (kind)
            CYC_CTRL: wr_addr = addr;
            CYC_STEP: wr_addr = nxt_addr;
            default:  wr_addr = cur_addr;
        endcase
    end

    // Burst state and registered read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            cnt_q     <= '0;
            open_q    <= 1'b0;
            rd_en_q   <= 1'b0;
            rd_addr_q <= '0;
            hold_q    <= 1'b0;
        end else begin
            case (kind)
                CYC_HOST: begin
                    base_q    <= addr;
                    cnt_q     <= '0;
                    open_q    <= 1'b1;
                    rd_en_q   <= 1'b1;
                    rd_addr_q <= addr;
                    hold_q    <= 1'b0;
                end
                CYC_CTRL: begin
                    base_q    <= addr;
                    cnt_q     <= '0;
                    open_q    <= 1'b1;
                    rd_en_q   <= ~is_wr;
                    rd_addr_q <= addr;
                    hold_q    <= 1'b0;
                end
                CYC_STEP: begin
                    cnt_q     <= cnt_nxt;
                    rd_en_q   <= ~is_wr;
                    rd_addr_q <= nxt_addr;
                    hold_q    <= 1'b0;
                end
                CYC_SUSP: begin
                    rd_en_q   <= 1'b0;
                    hold_q    <= ~is_wr;
                end
                default: begin
                    open_q    <= open_q & ~doze & (kind != CYC_DESEL);
                    rd_en_q   <= 1'b0;
                    hold_q    <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sbs_array.sv
// Storage array built from one memory per byte lane.
// Writes land on the clock edge; the read port is asynchronous and is
// sampled by the output register. No reset on the contents.
module sbs_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Store this lane when it is selected.
        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g])
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        // Read this lane at the registered read address.
        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/sbs_outreg.sv
// Output register and bus-drive flag.
// Loads read data one edge after the read request was registered; keeps
// the drive flag on suspend cycles and clears it otherwise.
module sbs_outreg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              doze,
    input  logic              rd_en,
    input  logic              hold,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] q,
    output logic              drive
);
    // Output data and drive flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            drive <= 1'b0;
        end else if (doze) begin
            drive <= 1'b0;
        end else if (rd_en) begin
            q     <= rd_data;
            drive <= 1'b1;
        end else if (!hold) begin
            drive <= 1'b0;
        end
    end

endmodule

// File: rtl/sync_burst_sram.sv
// Pipelined synchronous burst SRAM, top level.
// Ties the cycle decoder, the lane array and the output register
// together and gates the bus drive with the asynchronous output enable.
// Assumes the caller deselects the block before raising doze.
module sync_burst_sram #(
    parameter int ADDR_W      = 8,
    parameter int LANES       = 4,
    parameter int LANE_W      = 8,
    parameter bit INTERLEAVED = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    en_a_n,
    input  logic                    en_b,
    input  logic                    en_c_n,
    input  logic                    host_start_n,
    input  logic                    ctrl_start_n,
    input  logic                    step_n,
    input  logic                    write_all_n,
    input  logic                    lane_wr_en_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    out_en_n,
    input  logic                    doze,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    localparam int DATA_W = LANES * LANE_W;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [LANES-1:0]  wr_mask;
    logic              rd_en_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              hold_q;
    logic [DATA_W-1:0] rd_data;
    logic              drive;

    sbs_ctrl #(
        .ADDR_W(ADDR_W), .LANES(LANES), .INTERLEAVED(INTERLEAVED)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .host_start_n(host_start_n), .ctrl_start_n(ctrl_start_n),
        .step_n(step_n), .write_all_n(write_all_n),
        .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
        .doze(doze),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask),
        .rd_en_q(rd_en_q), .rd_addr_q(rd_addr_q), .hold_q(hold_q)
    );

    sbs_array #(
        .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
    ) array_i (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask),
        .wr_data(din), .rd_addr(rd_addr_q), .rd_data(rd_data)
    );

    sbs_outreg #(
        .DATA_W(DATA_W)
    ) out_i (
        .clk(clk), .rst_n(rst_n), .doze(doze), .rd_en(rd_en_q),
        .hold(hold_q), .rd_data(rd_data), .q(dout), .drive(drive)
    );

    // Asynchronous output-enable gating of the bus drive.
    assign dout_en = drive & ~out_en_n;

endmodule

// File: rtl/sbs_checker.sv
// Temporal checks on the burst SRAM ports, bound into every instance.
// Assumes deselection before doze and no doze release right after a
// watched read strobe.
module sbs_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_a_n,
    input logic             en_b,
    input logic             en_c_n,
    input logic             host_start_n,
    input logic             ctrl_start_n,
    input logic             write_all_n,
    input logic             lane_wr_en_n,
    input logic [LANES-1:0] lane_sel_n,
    input logic             out_en_n,
    input logic             doze,
    input logic             dout_en
);
    logic sel_in;
    logic wr_in;

    // Port-level view of selection and write intent.
    always_comb begin
        sel_in = ~en_a_n & en_b & ~en_c_n;
        wr_in  = ~write_all_n | (~lane_wr_en_n & ~(&lane_sel_n));
    end

    assert_deselect_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && (!host_start_n || !ctrl_start_n) && !sel_in) |=> ##1 !dout_en);

    assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && !host_start_n && sel_in) ##1 !doze |=> (out_en_n || doze || dout_en));

    assert_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && host_start_n && !ctrl_start_n && sel_in && wr_in) |=> ##1 !dout_en);

    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dout_en);

    assert_doze_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        doze |=> !dout_en);

    assert_host_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && !host_start_n && !ctrl_start_n && sel_in) ##1 !doze
        |=> (out_en_n || doze || dout_en));

endmodule

bind sync_burst_sram sbs_checker #(.LANES(LANES)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .host_start_n(host_start_n), .ctrl_start_n(ctrl_start_n),
    .write_all_n(write_all_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .doze(doze),
    .dout_en(dout_en)
);

// File: tb/sync_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sync_burst_sram_tb_top;
    localparam int AW = 4;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          en_a_n = 1'b0, en_b = 1'b1, en_c_n = 1'b0;
    logic          host_start_n = 1'b1, ctrl_start_n = 1'b1, step_n = 1'b1;
    logic          write_all_n = 1'b1, lane_wr_en_n = 1'b1;
    logic [3:0]    lane_sel_n = 4'hF;
    logic          out_en_n = 1'b0, doze = 1'b0;
    logic [31:0]   din = '0;
    logic [31:0]   dout_i, dout_x;
    logic          dout_en_i, dout_en_x;

    logic [31:0]   exp_lin [NW];
    logic [31:0]   exp_il  [NW];
    int            n_chk = 0;
    int            n_fail = 0;

    always #4 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .INTERLEAVED(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .host_start_n(host_start_n), .ctrl_start_n(ctrl_start_n),
        .step_n(step_n), .write_all_n(write_all_n),
        .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
        .out_en_n(out_en_n), .doze(doze), .din(din),
        .dout(dout_i), .dout_en(dout_en_i));

    sync_burst_sram #(.ADDR_W(AW), .INTERLEAVED(1'b1)) dut_x (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .host_start_n(host_start_n), .ctrl_start_n(ctrl_start_n),
        .step_n(step_n), .write_all_n(write_all_n),
        .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
        .out_en_n(out_en_n), .doze(doze), .din(din),
        .dout(dout_x), .dout_en(dout_en_x));

    task automatic idle();
        host_start_n = 1'b1; ctrl_start_n = 1'b1; step_n = 1'b1;
        write_all_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 4'hF;
        en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
        out_en_n = 1'b0; doze = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [AW-1:0] a, input logic [31:0] d);
        ctrl_start_n = 1'b0; addr = a; din = d;
        write_all_n = 1'b0; lane_wr_en_n = 1'b0; lane_sel_n = 4'b1010;
        tick();
        idle();
        exp_lin[a] = d;
        exp_il[a]  = d;
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input string req);
        host_start_n = 1'b0; addr = a;
        tick();
        idle();
        tick();
        check(req, dout_i, exp_lin[a]);
        check(req, dout_x, exp_il[a]);
        check(req, {31'b0, dout_en_i}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R12: reset state and a step with no open burst
        check("R12 reset", {31'b0, dout_en_i}, 32'd0);
        check("R12 reset", {31'b0, dout_en_x}, 32'd0);
        step_n = 1'b0; tick(); idle(); tick();
        check("R12 step", {31'b0, dout_en_i}, 32'd0);

        // R3, R11: fill every word with write-all, then read back via R2
        for (int a = 0; a < NW; a++)
            write_word(AW'(a), 32'h0F0F_0F0F + 32'h1357_9BDF * a);
        for (int a = 0; a < NW; a++)
            read_chk(AW'(a), "R2 R3 R11 sweep");

        // R4: every lane mask on word 3
        for (int m = 0; m < 16; m++) begin
            logic [31:0] d;
            d = 32'h1111_1111 * (m + 1);
            ctrl_start_n = 1'b0; addr = 3; din = d;
            write_all_n = 1'b1; lane_wr_en_n = 1'b0; lane_sel_n = ~4'(m);
            tick();
            idle();
            for (int l = 0; l < 4; l++)
                if (m[l]) begin
                    exp_lin[3][l*8 +: 8] = d[l*8 +: 8];
                    exp_il[3][l*8 +: 8]  = d[l*8 +: 8];
                end
            tick();
            if (m == 0) check("R4 all lanes off reads", {31'b0, dout_en_i}, 32'd1);
            read_chk(3, "R4 lane mask");
        end

        // R5: lane enable off is a read
        ctrl_start_n = 1'b0; addr = 5; din = 32'hBAD0_BAD0;
        write_all_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 4'h0;
        tick(); idle(); tick();
        check("R5 read", dout_i, exp_lin[5]);
        check("R5 drive", {31'b0, dout_en_i}, 32'd1);

        // R6: bus quiet after write through suspend, back on after step
        read_chk(1, "R6 pre");
        write_word(2, 32'hC0DE_0002);
        tick();
        check("R6 after write", {31'b0, dout_en_i}, 32'd0);
        tick();
        check("R6 suspend", {31'b0, dout_en_i}, 32'd0);
        step_n = 1'b0; tick(); idle(); tick();
        check("R6 step drives", {31'b0, dout_en_i}, 32'd1);
        check("R6 step data lin", dout_i, exp_lin[3]);
        check("R6 step data il", dout_x, exp_il[3]);

        // R7: read burst from 9 (low bits 01), five beats with wrap
        host_start_n = 1'b0; addr = 9;
        tick();
        for (int i = 1; i <= 5; i++) begin
            host_start_n = 1'b1;
            step_n = (i <= 4) ? 1'b0 : 1'b1;
            tick();
            check("R7 burst lin", dout_i, exp_lin[8 | ((1 + (i - 1)) & 3)]);
            check("R7 burst il",  dout_x, exp_il[8 | (1 ^ ((i - 1) & 3))]);
        end
        idle();

        // R7: write burst from 13 (low bits 01)
        for (int c = 0; c < 4; c++) begin
            if (c == 0) begin ctrl_start_n = 1'b0; addr = 13; end
            else begin ctrl_start_n = 1'b1; step_n = 1'b0; end
            write_all_n = 1'b0; din = 32'hB000_0000 + c;
            tick();
            exp_lin[12 | ((1 + c) & 3)] = 32'hB000_0000 + c;
            exp_il[12 | (1 ^ c)]        = 32'hB000_0000 + c;
        end
        idle(); tick();
        for (int a = 12; a < 16; a++) read_chk(AW'(a), "R7 write burst");

        // R13: suspend holds output
        read_chk(8, "R13 pre");
        repeat (3) tick();
        check("R13 hold data", dout_i, exp_lin[8]);
        check("R13 hold drive", {31'b0, dout_en_i}, 32'd1);

        // R8: asynchronous output enable, pipeline unaffected
        read_chk(5, "R8 pre");
        out_en_n = 1'b1; #1;
        check("R8 oe off", {31'b0, dout_en_i}, 32'd0);
        host_start_n = 1'b0; addr = 6;
        tick();
        host_start_n = 1'b1;
        tick();
        check("R8 oe off during read", {31'b0, dout_en_i}, 32'd0);
        out_en_n = 1'b0; #1;
        check("R8 oe back", {31'b0, dout_en_i}, 32'd1);
        check("R8 data kept", dout_i, exp_lin[6]);

        // R1: every non-selecting enable pattern
        for (int c = 0; c < 8; c++) begin
            if (c != 3'b010) begin
                {en_a_n, en_b, en_c_n} = 3'(c);
                ctrl_start_n = 1'b0; addr = 7; write_all_n = 1'b0;
                din = 32'hDEAD_0000 | c;
                tick(); idle(); tick();
                check("R1 deselect off", {31'b0, dout_en_i}, 32'd0);
            end
        end
        read_chk(7, "R1 no write");

        // R10: both strobes, host wins, write ignored
        host_start_n = 1'b0; ctrl_start_n = 1'b0; addr = 4;
        write_all_n = 1'b0; din = 32'hFFFF_0000;
        tick(); idle(); tick();
        check("R10 host read", dout_i, exp_lin[4]);
        check("R10 drive", {31'b0, dout_en_i}, 32'd1);
        read_chk(4, "R10 no write");

        // R9: deselect, doze, strobes ignored
        host_start_n = 1'b0; en_a_n = 1'b1;
        tick(); idle(); tick();
        check("R9 desel", {31'b0, dout_en_i}, 32'd0);
        doze = 1'b1; tick();
        ctrl_start_n = 1'b0; addr = 0; write_all_n = 1'b0; din = 32'hFFFF_FFFF;
        tick();
        ctrl_start_n = 1'b1; write_all_n = 1'b1; host_start_n = 1'b0;
        tick();
        host_start_n = 1'b1;
        tick();
        check("R9 asleep", {31'b0, dout_en_i}, 32'd0);
        doze = 1'b0; tick(); tick();
        check("R9 wake quiet", {31'b0, dout_en_i}, 32'd0);
        read_chk(0, "R9 kept");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule